// File: doc/BRIEF.md
# PC Keyboard Controller Command Engine

This block is the host-side command processor of a legacy PC keyboard and auxiliary-device controller. The host reaches it through two byte-wide ports, chosen by a single address bit. The command port (`addr`=1) accepts one-byte controller commands, and the status byte can always be read on `status_o`. The data port (`addr`=0) has two uses. It supplies the parameter byte of a two-stage command that is still pending. When nothing is pending, it passes the byte on to the keyboard device.

The engine holds three registers: mode, status and output port. It answers readback and self-test commands by pushing one byte into the keyboard reply queue, or into the auxiliary reply queue. It also drives a one-cycle system-reset request and the A20 gate line. Two inputs report whether the keyboard or the auxiliary side has a byte waiting. From these and the mode byte, the engine derives the interrupt lines and the buffer-full flags.

Top module: `kbc_cmd_engine`

## Requirements
- R1: After reset, the mode register is 0x03, `status_o` is 0x18 when neither device has data, the output port reads back as 0x03, `a20_gate` is 1 and `xlate_en` is 0.
- R2: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 arm a pending state that routes the next data-port write. After that write the pending state clears, so the write after it goes to the keyboard again. Through 0x60 the data byte replaces the whole mode byte.
- R3: Through 0xD1 the data byte replaces the output port. `a20_gate` then follows bit 1 of that byte, and a reset pulse is requested when bit 0 is 0.
- R4: Through 0xD2 the data byte is pushed to the keyboard reply queue. Through 0xD3 it is pushed to the auxiliary reply queue. Through 0xD4 it is sent to the auxiliary device (`aux_tx_valid`).
- R5: A data-port write with nothing pending is sent to the keyboard device (`kbd_tx_valid`, `tx_data`).
- R6: Command 0x20 pushes the mode byte to the keyboard reply queue. Command 0xD0 pushes the output port with bit 4 = any device has data and bit 5 = only the auxiliary side has data.
- R7: Command 0xAA sets status bit 2 and pushes 0x55. Commands 0xA9, 0xAB and 0xC0 each push 0x00.
- R8: Commands 0xAD and 0xAE set and clear mode bit 4 (keyboard disable), which gates `irq_kbd` from the next cycle on. Commands 0xA7 and 0xA8 set and clear mode bit 5.
- R9: A command with upper nibble 0xF requests a system reset if its bit 0 is 0, and does nothing otherwise.
- R10: Command 0xDF sets output-port bit 1 and raises `a20_gate`. Command 0xDD clears both.
- R11: Any other command code changes no register, pushes nothing and sends nothing.
- R12: Status bit 0 is set when any device has data, and bit 5 when only the auxiliary side has. `irq_kbd` = keyboard data waiting & mode bit 0 & !mode bit 4. `irq_aux` = only auxiliary data waiting & mode bit 1. `xlate_en` is mode bit 6.
- R13: `sys_reset_req` is a single-cycle pulse, one cycle after the write that requests it. Every push and send strobe is likewise one cycle long, one cycle after its write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| addr | input | 1 | 1 = command port, 0 = data port |
| wr_data | input | 8 | Host write byte |
| kbd_avail | input | 1 | Keyboard side has a byte waiting |
| aux_avail | input | 1 | Auxiliary side has a byte waiting |
| status_o | output | 8 | Status byte |
| kbd_q_push | output | 1 | Push `reply_data` into the keyboard reply queue |
| aux_q_push | output | 1 | Push `reply_data` into the auxiliary reply queue |
| reply_data | output | 8 | Reply byte |
| kbd_tx_valid | output | 1 | Send `tx_data` to the keyboard device |
| aux_tx_valid | output | 1 | Send `tx_data` to the auxiliary device |
| tx_data | output | 8 | Byte for a device |
| sys_reset_req | output | 1 | One-cycle system reset request |
| a20_gate | output | 1 | A20 gate level |
| xlate_en | output | 1 | Scan-code translation enable |
| irq_kbd | output | 1 | Keyboard interrupt |
| irq_aux | output | 1 | Auxiliary interrupt |

## Verification
Two functions can coincide in one cycle. The first is a register-changing command, such as keyboard disable or output-port readback. The second is the live data-available tracking that drives the interrupts and the buffer-full bits. The bench holds `kbd_avail` and `aux_avail` at fixed combinations while it issues 0xAD, 0xAE and 0xD0. It then checks two things: that `irq_kbd` drops and returns on the cycle after each command, and that the pushed output-port byte carries the flags current in that cycle. Every one of the 256 command codes is swept from reset, with its two-stage follow-up where one applies. The results are judged by readback against a model computed in the bench.

// File: rtl/kbc_cmd_engine.sv
module kbc_cmd_engine #(
  parameter logic [7:0] MODE_INIT = 8'h03,
  parameter logic [7:0] STAT_INIT = 8'h18,
  parameter logic [7:0] OUTP_INIT = 8'h03
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       addr,
  input  logic [7:0] wr_data,
  input  logic       kbd_avail,
  input  logic       aux_avail,
  output logic [7:0] status_o,
  output logic       kbd_q_push,
  output logic       aux_q_push,
  output logic [7:0] reply_data,
  output logic       kbd_tx_valid,
  output logic       aux_tx_valid,
  output logic [7:0] tx_data,
  output logic       sys_reset_req,
  output logic       a20_gate,
  output logic       xlate_en,
  output logic       irq_kbd,
  output logic       irq_aux
);
  logic [7:0] mode_q, stat_q, outp_q, pend_q;
  logic       any_full, aux_only;

  assign any_full = kbd_avail | aux_avail;
  assign aux_only = aux_avail & ~kbd_avail;
  assign status_o = {stat_q[7:6], aux_only, stat_q[4:1], any_full};
  assign a20_gate = outp_q[1];
  assign xlate_en = mode_q[6];
  assign irq_kbd  = kbd_avail & mode_q[0] & ~mode_q[4];
  assign irq_aux  = aux_only & mode_q[1];

  wire cmd_wr  = wr_en & addr;
  wire data_wr = wr_en & ~addr;
  wire [7:0] outp_rd = {outp_q[7:6], aux_only, any_full, outp_q[3:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q        <= MODE_INIT;
      stat_q        <= STAT_INIT;
      outp_q        <= OUTP_INIT;
      pend_q        <= 8'h00;
      kbd_q_push    <= 1'b0;
      aux_q_push    <= 1'b0;
      reply_data    <= 8'h00;
      kbd_tx_valid  <= 1'b0;
      aux_tx_valid  <= 1'b0;
      tx_data       <= 8'h00;
      sys_reset_req <= 1'b0;
    end else begin
      kbd_q_push    <= 1'b0;
      aux_q_push    <= 1'b0;
      kbd_tx_valid  <= 1'b0;
      aux_tx_valid  <= 1'b0;
      sys_reset_req <= 1'b0;
      if (cmd_wr) begin
        if (wr_data[7:4] == 4'hF) begin
          sys_reset_req <= ~wr_data[0];
        end else begin
          case (wr_data)
            8'h20: begin kbd_q_push <= 1'b1; reply_data <= mode_q; end
            8'hD0: begin kbd_q_push <= 1'b1; reply_data <= outp_rd; end
            8'h60, 8'hD1, 8'hD2, 8'hD3, 8'hD4: pend_q <= wr_data;
            8'hA7: mode_q[5] <= 1'b1;
            8'hA8: mode_q[5] <= 1'b0;
            8'hAD: mode_q[4] <= 1'b1;
            8'hAE: mode_q[4] <= 1'b0;
            8'hAA: begin
              stat_q[2]  <= 1'b1;
              kbd_q_push <= 1'b1;
              reply_data <= 8'h55;
            end
            8'hA9, 8'hAB, 8'hC0: begin kbd_q_push <= 1'b1; reply_data <= 8'h00; end
            8'hDF: outp_q[1] <= 1'b1;
            8'hDD: outp_q[1] <= 1'b0;
            default: ;
          endcase
        end
      end else if (data_wr) begin
        pend_q <= 8'h00;
        case (pend_q)
          8'h60: mode_q <= wr_data;
          8'hD1: begin
            outp_q        <= wr_data;
            sys_reset_req <= ~wr_data[0];
          end
          8'hD2: begin kbd_q_push <= 1'b1; reply_data <= wr_data; end
          8'hD3: begin aux_q_push <= 1'b1; reply_data <= wr_data; end
          8'hD4: begin aux_tx_valid <= 1'b1; tx_data <= wr_data; end
          default: begin kbd_tx_valid <= 1'b1; tx_data <= wr_data; end
        endcase
      end
    end
  end
endmodule

// File: rtl/kbc_cmd_engine_chk.sv
module kbc_cmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       addr,
  input logic [7:0] wr_data,
  input logic [7:0] pend_q,
  input logic [7:0] status_o,
  input logic       kbd_q_push,
  input logic [7:0] reply_data,
  input logic       sys_reset_req,
  input logic       a20_gate,
  input logic       irq_kbd,
  input logic       irq_aux
);
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |=> !sys_reset_req); // R13
  AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr) |=> pend_q == 8'h00); // R2
  AST_SELFTEST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && wr_data == 8'hAA) |=> (status_o[2] && kbd_q_push && reply_data == 8'h55)); // R7
  AST_KBD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && wr_data == 8'hAD) |=> !irq_kbd); // R8
  AST_A20_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && wr_data == 8'hDF) |=> a20_gate); // R10
  AST_A20_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && wr_data == 8'hDD) |=> !a20_gate); // R10
  AST_NOP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && wr_data[7:4] == 4'hF && wr_data[0]) |=> !sys_reset_req); // R9
  AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_kbd && irq_aux)); // R12
  AST_IRQ_AUX_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_aux |-> (status_o[5] && status_o[0])); // R12
endmodule

bind kbc_cmd_engine kbc_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .pend_q(pend_q), .status_o(status_o), .kbd_q_push(kbd_q_push),
  .reply_data(reply_data), .sys_reset_req(sys_reset_req), .a20_gate(a20_gate),
  .irq_kbd(irq_kbd), .irq_aux(irq_aux)
);

// File: tb/test_kbc_cmd_engine.sv
module test_kbc_cmd_engine;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic kbd_avail = 1'b0, aux_avail = 1'b0;
  logic [7:0] status_o, reply_data, tx_data;
  logic kbd_q_push, aux_q_push, kbd_tx_valid, aux_tx_valid;
  logic sys_reset_req, a20_gate, xlate_en, irq_kbd, irq_aux;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  kbc_cmd_engine i_kbc_cmd_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .kbd_avail(kbd_avail), .aux_avail(aux_avail), .status_o(status_o),
    .kbd_q_push(kbd_q_push), .aux_q_push(aux_q_push), .reply_data(reply_data),
    .kbd_tx_valid(kbd_tx_valid), .aux_tx_valid(aux_tx_valid), .tx_data(tx_data),
    .sys_reset_req(sys_reset_req), .a20_gate(a20_gate), .xlate_en(xlate_en),
    .irq_kbd(irq_kbd), .irq_aux(irq_aux)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; wr_en = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  function automatic bit is_pend(logic [7:0] c);
    return c == 8'h60 || (c >= 8'hD1 && c <= 8'hD4);
  endfunction

  function automatic bit is_known(logic [7:0] c);
    return c[7:4] == 4'hF || is_pend(c) || c == 8'h20 || c == 8'hD0 ||
           c == 8'hA7 || c == 8'hA8 || c == 8'hA9 || c == 8'hAA || c == 8'hAB ||
           c == 8'hAD || c == 8'hAE || c == 8'hC0 || c == 8'hDD || c == 8'hDF;
  endfunction

  initial begin
    #2ms;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R13 act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // Full command sweep from reset
    for (int c = 0; c < 256; c++) begin
      logic [7:0] cmd, e_mode, e_outp, e_stat, e_push_d;
      bit e_push, e_rst;
      string tag;
      cmd = c[7:0];
      e_mode = 8'h03; e_outp = 8'h03; e_stat = 8'h18;
      e_push = 0; e_push_d = 8'h00; e_rst = 0;
      tag = is_known(cmd) ? "R7" : "R11";
      do_reset();
      if (c == 0) begin
        chk("R1 status", status_o, 8'h18);
        chk("R1 a20", {7'd0, a20_gate}, 8'h01);
        chk("R1 xlate", {7'd0, xlate_en}, 8'h00);
      end
      case (cmd)
        8'h20: begin e_push = 1; e_push_d = 8'h03; tag = "R6"; end
        8'hD0: begin e_push = 1; e_push_d = 8'h03; tag = "R6"; end
        8'hAA: begin e_push = 1; e_push_d = 8'h55; e_stat = 8'h1C; end
        8'hA9, 8'hAB, 8'hC0: e_push = 1;
        8'hA7: begin e_mode = 8'h23; tag = "R8"; end
        8'hAD: begin e_mode = 8'h13; tag = "R8"; end
        8'hA8, 8'hAE: tag = "R8";
        8'hDD: begin e_outp = 8'h01; tag = "R10"; end
        8'hDF: tag = "R10";
        default: ;
      endcase
      if (cmd[7:4] == 4'hF) begin e_rst = !cmd[0]; tag = "R9"; end
      wr(1'b1, cmd);
      chk(tag, {7'd0, kbd_q_push}, {7'd0, e_push});
      if (e_push) chk(tag, reply_data, e_push_d);
      chk(tag, {7'd0, sys_reset_req}, {7'd0, e_rst});
      chk(tag, {5'd0, aux_q_push, kbd_tx_valid, aux_tx_valid}, 8'h00);
      @(negedge clk);
      chk("R13 pulse", {6'd0, sys_reset_req, kbd_q_push}, 8'h00);
      if (is_pend(cmd)) begin
        wr(1'b0, 8'hA5);
        chk("R4 kq", {7'd0, kbd_q_push}, {7'd0, cmd == 8'hD2});
        chk("R4 aq", {7'd0, aux_q_push}, {7'd0, cmd == 8'hD3});
        chk("R4 atx", {7'd0, aux_tx_valid}, {7'd0, cmd == 8'hD4});
        chk("R2 ktx", {7'd0, kbd_tx_valid}, 8'h00);
        if (cmd inside {8'hD2, 8'hD3}) chk("R4 reply", reply_data, 8'hA5);
        if (cmd == 8'hD4) chk("R4 tx", tx_data, 8'hA5);
        chk("R3 rst", {7'd0, sys_reset_req}, 8'h00);
        if (cmd == 8'h60) e_mode = 8'hA5;
        if (cmd == 8'hD1) e_outp = 8'h85;
        wr(1'b0, 8'h3C);
        chk("R2 cleared", {7'd0, kbd_tx_valid}, 8'h01);
        chk("R5 tx", tx_data, 8'h3C);
      end
      chk({tag, " status"}, status_o, e_stat);
      chk({tag, " a20"}, {7'd0, a20_gate}, {7'd0, e_outp[1]});
      chk("R12 xlate", {7'd0, xlate_en}, {7'd0, e_mode[6]});
      wr(1'b1, 8'h20);
      chk({tag, " mode"}, reply_data, e_mode);
      wr(1'b1, 8'hD0);
      chk({tag, " outp"}, reply_data, e_outp);
    end

    // Directed: output port write with reset bit low, A20 high
    do_reset();
    wr(1'b1, 8'hD1); wr(1'b0, 8'h02);
    chk("R3 rst", {7'd0, sys_reset_req}, 8'h01);
    chk("R3 a20", {7'd0, a20_gate}, 8'h01);
    @(negedge clk);
    chk("R13 pulse", {7'd0, sys_reset_req}, 8'h00);

    // Directed: mode byte with translation bit
    wr(1'b1, 8'h60); wr(1'b0, 8'h41);
    chk("R2 xlate", {7'd0, xlate_en}, 8'h01);
    wr(1'b1, 8'h20);
    chk("R2 mode", reply_data, 8'h41);

    // Directed: no pending data write
    do_reset();
    wr(1'b0, 8'h9E);
    chk("R5 valid", {6'd0, kbd_tx_valid, aux_tx_valid}, 8'h02);
    chk("R5 data", tx_data, 8'h9E);

    // Collision: data-available tracking with commands
    for (int v = 0; v < 4; v++) begin
      logic [7:0] fl;
      do_reset();
      kbd_avail = v[0]; aux_avail = v[1];
      fl = {2'b00, v[1] & !v[0], v[0] | v[1], 4'b0000};
      @(negedge clk);
      chk("R12 status", status_o, 8'h18 | {2'b00, fl[5], 4'b0000, fl[4]});
      chk("R12 irqk", {7'd0, irq_kbd}, {7'd0, v[0]});
      chk("R12 irqa", {7'd0, irq_aux}, {7'd0, v[1] & !v[0]});
      wr(1'b1, 8'hD0);
      chk("R6 outp flags", reply_data, 8'h03 | fl);
      wr(1'b1, 8'hAD);
      chk("R8 irq off", {7'd0, irq_kbd}, 8'h00);
      wr(1'b1, 8'hAE);
      chk("R8 irq on", {7'd0, irq_kbd}, {7'd0, v[0]});
      wr(1'b1, 8'h60); wr(1'b0, 8'h00);
      chk("R12 irq masked", {6'd0, irq_kbd, irq_aux}, 8'h00);
    end
    kbd_avail = 0; aux_avail = 0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule